// File: doc/BRIEF.md
# Interrupt-Return Privilege Checker

This unit validates the selectors and descriptors used by a return-from-interrupt operation in protected and long mode. A start pulse captures the popped code and stack selectors, the back-link selector, the current privilege level, a long-mode flag and the nested-task flag. The unit then runs its checks in a fixed order. It asks for each descriptor it needs over a valid/ready handshake, and it stops at the first violation.

The result is one of two things. It can be a success with a return kind: same privilege level, outer privilege level, or a return to the linked task. Otherwise it is a fault class with a 16-bit error code. Error codes carry the offending selector with bits [1:0] cleared. A null selector, or a nested return in long mode, reports code zero. The descriptor table lookup and the task switch itself happen outside the unit. Only the descriptor fields reach it: type, system/segment bit, DPL, present bit and the 64-bit code bit.

Top module: `iret_priv_check`

## Requirements
- R1: After reset `done` is 0, `desc_ready` is 0, `fault` is 00 and `path` is 00.
- R2: A start pulse is accepted only while no check is in progress. A start during a check is ignored and does not change its result.
- R3: A nested-task return with `long_mode` set finishes two cycles after start with general protection (`fault`=01) and code 0, with no descriptor fetch.
- R4: A nested-task back-link selector with bit 2 (table indicator) set gives invalid TSS (`fault`=10) with code `link_sel & 16'hFFFC`, with no fetch.
- R5: The back-link descriptor must have `desc_s`=0 and type 4'h3 or 4'hB, else invalid TSS. If the type passes but `desc_present` is 0, the fault is not-present (`fault`=11). Both faults carry the masked link selector. A passing descriptor gives `path`=11 (task return).
- R6: When not nested, a code selector whose bits [15:2] are zero gives general protection with code 0 and no fetch.
- R7: After the code descriptor arrives, a code RPL (bits [1:0]) below `cpl` gives general protection with the masked code selector. A code RPL equal to `cpl` gives `path`=01 (same level).
- R8: On the outer path, a null stack selector (bits [15:2] zero) gives `path`=10 only when `long_mode` is set, the code descriptor has `desc_long`=1 and the code RPL is not 3. Otherwise it gives general protection with code 0.
- R9: On the outer path, a non-null stack selector whose RPL differs from the code RPL gives general protection with the masked stack selector, before any stack fetch.
- R10: The stack descriptor is checked in this order: writable data segment (`desc_s`=1, type bit 3 clear, type bit 1 set), then DPL equal to the code RPL, then present. The first two give general protection and the last gives not-present, each with the masked stack selector. If all pass, `path`=10.
- R11: Encodings are `fault` 00 none, 01 general protection, 10 invalid TSS, 11 not present, and `path` 00 none, 01 same, 10 outer, 11 task. Exactly one of `fault` and `path` is non-zero while `done` is high, `err_code[1:0]` is 0, and the result holds until the next accepted start.
- R12: `desc_ready` is high only while a descriptor is awaited, and `desc_sel` then shows the selector being looked up: link, then code, then stack. `desc_valid` has no effect while `desc_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a check; inputs below are captured |
| long_mode | input | 1 | Processor is in long mode |
| nested | input | 1 | Nested-task flag |
| cpl | input | 2 | Current privilege level |
| cs_sel | input | 16 | Popped code selector |
| ss_sel | input | 16 | Popped stack selector |
| link_sel | input | 16 | Back-link selector from the current task state |
| desc_valid | input | 1 | Descriptor fields are valid |
| desc_type | input | 4 | Descriptor type field |
| desc_s | input | 1 | 1 for code/data segment, 0 for system descriptor |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_present | input | 1 | Present bit |
| desc_long | input | 1 | 64-bit code segment bit |
| desc_ready | output | 1 | Unit is waiting for a descriptor |
| desc_sel | output | 16 | Selector whose descriptor is wanted |
| done | output | 1 | Result is valid |
| fault | output | 2 | Fault class |
| err_code | output | 16 | Error code |
| path | output | 2 | Return kind on success |

## Verification
Nested returns are tried in both modes and with every link descriptor defect. This separates the early table-indicator fault from the type fault and the not-present fault. Non-nested returns cover every privilege relation between code RPL and CPL, plus stack descriptors with several defects at once. These show that the first failing check in order wins, for example a not-present stack with a bad DPL must report the DPL fault. Null stack selectors are run in legacy and long mode against 64-bit and non-64-bit code and against RPL 3, which isolates each term of the null allowance. Descriptor gaps of varying length, start pulses sent mid-check and stray `desc_valid` pulses while idle show that the handshake and the start capture cannot disturb a result.

// File: rtl/iret_pkg.sv
package iret_pkg;
  localparam int SEL_W  = 16;
  localparam int TYPE_W = 4;
  localparam logic [TYPE_W-1:0] TYPE_BUSY_TSS16 = 4'h3;
  localparam logic [TYPE_W-1:0] TYPE_BUSY_TSS32 = 4'hB;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_GP   = 2'b01,
    FLT_TS   = 2'b10,
    FLT_NP   = 2'b11
  } fault_e;

  typedef enum logic [1:0] {
    RET_NONE  = 2'b00,
    RET_SAME  = 2'b01,
    RET_OUTER = 2'b10,
    RET_TASK  = 2'b11
  } path_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_LINK,
    ST_CODE,
    ST_STACK
  } state_e;

  function automatic logic [SEL_W-1:0] sel_mask(input logic [SEL_W-1:0] s);
    return {s[SEL_W-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/iret_sel_check.sv
module iret_sel_check
  import iret_pkg::*;
(
  input  logic [SEL_W-1:0] cs_sel,
  input  logic [SEL_W-1:0] ss_sel,
  input  logic [SEL_W-1:0] link_sel,
  input  logic [1:0]       cpl,
  output logic             cs_null,
  output logic             ss_null,
  output logic             link_ti,
  output logic             cs_rpl_low,
  output logic             cs_rpl_same,
  output logic             ss_rpl_diff
);
  localparam int TI_BIT = 2;

  always_comb begin
    cs_null     = (cs_sel[SEL_W-1:2] == '0);
    ss_null     = (ss_sel[SEL_W-1:2] == '0);
    link_ti     = link_sel[TI_BIT];
    cs_rpl_low  = (cs_sel[1:0] < cpl);
    cs_rpl_same = (cs_sel[1:0] == cpl);
    ss_rpl_diff = (ss_sel[1:0] != cs_sel[1:0]);
  end
endmodule

// File: rtl/iret_desc_check.sv
module iret_desc_check
  import iret_pkg::*;
(
  input  logic              is_link,
  input  logic [TYPE_W-1:0] d_type,
  input  logic              d_s,
  input  logic [1:0]        d_dpl,
  input  logic              d_present,
  input  logic [1:0]        want_dpl,
  output fault_e            verdict
);
  logic link_type_ok;
  logic stack_type_ok;

  always_comb begin
    link_type_ok  = !d_s && ((d_type == TYPE_BUSY_TSS16) || (d_type == TYPE_BUSY_TSS32));
    stack_type_ok = d_s && !d_type[3] && d_type[1];
    verdict = FLT_NONE;
    if (is_link) begin
      if (!link_type_ok)   verdict = FLT_TS;
      else if (!d_present) verdict = FLT_NP;
    end else begin
      if (!stack_type_ok)          verdict = FLT_GP;
      else if (d_dpl != want_dpl)  verdict = FLT_GP;
      else if (!d_present)         verdict = FLT_NP;
    end
  end
endmodule

// File: rtl/iret_priv_check.sv
module iret_priv_check
  import iret_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              long_mode,
  input  logic              nested,
  input  logic [1:0]        cpl,
  input  logic [15:0]       cs_sel,
  input  logic [15:0]       ss_sel,
  input  logic [15:0]       link_sel,
  input  logic              desc_valid,
  input  logic [3:0]        desc_type,
  input  logic              desc_s,
  input  logic [1:0]        desc_dpl,
  input  logic              desc_present,
  input  logic              desc_long,
  output logic              desc_ready,
  output logic [15:0]       desc_sel,
  output logic              done,
  output logic [1:0]        fault,
  output logic [15:0]       err_code,
  output logic [1:0]        path
);
  state_e           st_q, st_n;
  logic             lm_q, lm_n, nt_q, nt_n;
  logic [1:0]       cpl_q, cpl_n;
  logic [SEL_W-1:0] cs_q, cs_n, ss_q, ss_n, lk_q, lk_n;
  logic             done_q, done_n;
  fault_e           flt_q, flt_n;
  path_e            path_q, path_n;
  logic [SEL_W-1:0] code_q, code_n;
  logic             cap_en, busy;

  logic   cs_null, ss_null, link_ti, cs_rpl_low, cs_rpl_same, ss_rpl_diff;
  fault_e dverdict;

  iret_sel_check u_sel (
    .cs_sel(cs_q), .ss_sel(ss_q), .link_sel(lk_q), .cpl(cpl_q),
    .cs_null(cs_null), .ss_null(ss_null), .link_ti(link_ti),
    .cs_rpl_low(cs_rpl_low), .cs_rpl_same(cs_rpl_same), .ss_rpl_diff(ss_rpl_diff)
  );

  iret_desc_check u_desc (
    .is_link(st_q == ST_LINK), .d_type(desc_type), .d_s(desc_s), .d_dpl(desc_dpl),
    .d_present(desc_present), .want_dpl(cs_q[1:0]), .verdict(dverdict)
  );

  assign busy   = (st_q != ST_IDLE);
  assign cap_en = start && !busy;

  always_comb begin
    st_n   = st_q;
    done_n = done_q;
    flt_n  = flt_q;
    path_n = path_q;
    code_n = code_q;
    lm_n   = lm_q;
    nt_n   = nt_q;
    cpl_n  = cpl_q;
    cs_n   = cs_q;
    ss_n   = ss_q;
    lk_n   = lk_q;
    unique case (st_q)
      ST_IDLE: if (cap_en) begin
        lm_n = long_mode; nt_n = nested; cpl_n = cpl;
        cs_n = cs_sel; ss_n = ss_sel; lk_n = link_sel;
        done_n = 1'b0; flt_n = FLT_NONE; path_n = RET_NONE; code_n = '0;
        st_n = ST_EVAL;
      end
      ST_EVAL: begin
        if (nt_q) begin
          if (lm_q) begin
            flt_n = FLT_GP; code_n = '0; done_n = 1'b1; st_n = ST_IDLE;
          end else if (link_ti) begin
            flt_n = FLT_TS; code_n = sel_mask(lk_q); done_n = 1'b1; st_n = ST_IDLE;
          end else begin
            st_n = ST_LINK;
          end
        end else if (cs_null) begin
          flt_n = FLT_GP; code_n = '0; done_n = 1'b1; st_n = ST_IDLE;
        end else begin
          st_n = ST_CODE;
        end
      end
      ST_LINK: if (desc_valid) begin
        done_n = 1'b1; st_n = ST_IDLE;
        if (dverdict != FLT_NONE) begin
          flt_n = dverdict; code_n = sel_mask(lk_q);
        end else begin
          path_n = RET_TASK;
        end
      end
      ST_CODE: if (desc_valid) begin
        done_n = 1'b1; st_n = ST_IDLE;
        if (cs_rpl_low) begin
          flt_n = FLT_GP; code_n = sel_mask(cs_q);
        end else if (cs_rpl_same) begin
          path_n = RET_SAME;
        end else if (ss_null) begin
          if (lm_q && desc_long && (cs_q[1:0] != 2'd3)) path_n = RET_OUTER;
          else begin flt_n = FLT_GP; code_n = '0; end
        end else if (ss_rpl_diff) begin
          flt_n = FLT_GP; code_n = sel_mask(ss_q);
        end else begin
          done_n = 1'b0; st_n = ST_STACK;
        end
      end
      ST_STACK: if (desc_valid) begin
        done_n = 1'b1; st_n = ST_IDLE;
        if (dverdict != FLT_NONE) begin
          flt_n = dverdict; code_n = sel_mask(ss_q);
        end else begin
          path_n = RET_OUTER;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      flt_q  <= FLT_NONE;
      path_q <= RET_NONE;
      code_q <= '0;
      lm_q   <= 1'b0;
      nt_q   <= 1'b0;
      cpl_q  <= '0;
      cs_q   <= '0;
      ss_q   <= '0;
      lk_q   <= '0;
    end else begin
      st_q   <= st_n;
      done_q <= done_n;
      flt_q  <= flt_n;
      path_q <= path_n;
      code_q <= code_n;
      if (cap_en) begin
        lm_q  <= lm_n;
        nt_q  <= nt_n;
        cpl_q <= cpl_n;
        cs_q  <= cs_n;
        ss_q  <= ss_n;
        lk_q  <= lk_n;
      end
    end
  end

  always_comb begin
    desc_ready = (st_q == ST_LINK) || (st_q == ST_CODE) || (st_q == ST_STACK);
    unique case (st_q)
      ST_LINK:  desc_sel = lk_q;
      ST_CODE:  desc_sel = cs_q;
      ST_STACK: desc_sel = ss_q;
      default:  desc_sel = '0;
    endcase
  end

  assign done     = done_q;
  assign fault    = flt_q;
  assign err_code = code_q;
  assign path     = path_q;

  AST_READY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |-> !done); // R12
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(fault) && $stable(err_code) && $stable(path))); // R11
  AST_CODE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_code[1:0] == 2'b00)); // R11
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((fault != 2'b00) != (path != 2'b00))); // R11
  AST_LONG_NESTED_GP: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && nested && long_mode) |-> ##2 (done && fault == 2'b01 && err_code == 16'h0)); // R3
  AST_NULL_CODE_GP: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !nested && cs_sel[15:2] == 14'h0) |-> ##2 (done && fault == 2'b01 && err_code == 16'h0)); // R6
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !done || (st_q == ST_IDLE)); // R2
endmodule

// File: tb/tb_iret_priv_check.sv
module tb_iret_priv_check;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, long_mode, nested;
  logic [1:0]  cpl;
  logic [15:0] cs_sel, ss_sel, link_sel;
  logic        desc_valid;
  logic [3:0]  desc_type;
  logic        desc_s, desc_present, desc_long;
  logic [1:0]  desc_dpl;
  logic        desc_ready, done;
  logic [15:0] desc_sel, err_code;
  logic [1:0]  fault, path;

  int checks = 0;
  int fails  = 0;

  // descriptor table seen by the bench: 0 link, 1 code, 2 stack
  logic [3:0] dty [3];
  logic       dsb [3];
  logic [1:0] ddp [3];
  logic       dpr [3];
  logic       dlg [3];

  always #10 clk = ~clk;

  iret_priv_check dut (
    .clk(clk), .rst_n(rst_n), .start(start), .long_mode(long_mode), .nested(nested),
    .cpl(cpl), .cs_sel(cs_sel), .ss_sel(ss_sel), .link_sel(link_sel),
    .desc_valid(desc_valid), .desc_type(desc_type), .desc_s(desc_s), .desc_dpl(desc_dpl),
    .desc_present(desc_present), .desc_long(desc_long), .desc_ready(desc_ready),
    .desc_sel(desc_sel), .done(done), .fault(fault), .err_code(err_code), .path(path)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input bit lm, input bit nt, input logic [1:0] cp,
      input logic [15:0] cs, input logic [15:0] ss, input logic [15:0] lk,
      output int f, output int c, output int p, output int nf);
    f = 0; c = 0; p = 0; nf = 0;
    if (nt) begin
      if (lm) begin f = 1; return; end
      if (lk[2]) begin f = 2; c = lk & 16'hFFFC; return; end
      nf = 1;
      if (dsb[0] || !(dty[0] == 4'h3 || dty[0] == 4'hB)) begin f = 2; c = lk & 16'hFFFC; end
      else if (!dpr[0]) begin f = 3; c = lk & 16'hFFFC; end
      else p = 3;
      return;
    end
    if ((cs >> 2) == 0) begin f = 1; return; end
    nf = 1;
    if (cs[1:0] < cp) begin f = 1; c = cs & 16'hFFFC; return; end
    if (cs[1:0] == cp) begin p = 1; return; end
    if ((ss >> 2) == 0) begin
      if (lm && dlg[1] && cs[1:0] != 3) p = 2; else f = 1;
      return;
    end
    if (ss[1:0] != cs[1:0]) begin f = 1; c = ss & 16'hFFFC; return; end
    nf = 2;
    if (!(dsb[2] && !dty[2][3] && dty[2][1])) begin f = 1; c = ss & 16'hFFFC; end
    else if (ddp[2] != cs[1:0]) begin f = 1; c = ss & 16'hFFFC; end
    else if (!dpr[2]) begin f = 3; c = ss & 16'hFFFC; end
    else p = 2;
  endfunction

  task automatic setd(input int k, input logic [3:0] t, input logic s, input logic [1:0] d,
                      input logic pr, input logic l);
    dty[k] = t; dsb[k] = s; ddp[k] = d; dpr[k] = pr; dlg[k] = l;
  endtask

  task automatic run(input string req, input bit lm, input bit nt, input logic [1:0] cp,
      input logic [15:0] cs, input logic [15:0] ss, input logic [15:0] lk,
      input int gap, input bit poke);
    int ef, ec, ep, enf, nf, cyc, which;
    logic [15:0] esel;
    bit poked;
    model(lm, nt, cp, cs, ss, lk, ef, ec, ep, enf);
    @(negedge clk);
    long_mode = lm; nested = nt; cpl = cp; cs_sel = cs; ss_sel = ss; link_sel = lk; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cs_sel = 16'h0; ss_sel = 16'h0; link_sel = 16'h0004; nested = ~nt;
    nf = 0; cyc = 0; poked = 1'b0;
    while (!done && cyc < 100) begin
      if (desc_ready) begin
        which = nt ? 0 : (nf == 0 ? 1 : 2);
        esel  = (which == 0) ? lk : (which == 1) ? cs : ss;
        chk(desc_sel == esel, "R12", "desc_sel", desc_sel, esel);
        if (poke && !poked) begin
          poked = 1'b1; start = 1'b1; @(negedge clk); start = 1'b0;
        end
        repeat (gap) @(negedge clk);
        desc_type = dty[which]; desc_s = dsb[which]; desc_dpl = ddp[which];
        desc_present = dpr[which]; desc_long = dlg[which]; desc_valid = 1'b1;
        @(negedge clk);
        desc_valid = 1'b0; desc_type = 4'h0; desc_s = 1'b0; desc_present = 1'b0; desc_long = 1'b0;
        nf++;
      end else @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, req, "done", done, 1);
    chk(fault == ef, req, "fault", fault, ef);
    chk(err_code == ec, req, "err_code", err_code, ec);
    chk(path == ep, req, "path", path, ep);
    chk(nf == enf, "R12", "fetch count", nf, enf);
    repeat (3) @(negedge clk);
    chk(done && fault == ef && err_code == ec && path == ep, "R11", "held result", {fault, path}, {ef[1:0], ep[1:0]});
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; long_mode = 1'b0; nested = 1'b0; cpl = 2'd0;
    cs_sel = 16'h0; ss_sel = 16'h0; link_sel = 16'h0;
    desc_valid = 1'b0; desc_type = 4'h0; desc_s = 1'b0; desc_dpl = 2'd0;
    desc_present = 1'b0; desc_long = 1'b0;
    for (int k = 0; k < 3; k++) setd(k, 4'h0, 1'b0, 2'd0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !desc_ready && fault == 2'b00 && path == 2'b00, "R1", "reset outputs",
        {done, desc_ready, fault, path}, 0);

    // stray descriptor strobe while idle: nothing changes (R12)
    desc_valid = 1'b1; @(negedge clk); desc_valid = 1'b0; @(negedge clk);
    chk(!done && !desc_ready, "R12", "idle desc_valid", {done, desc_ready}, 0);

    // nested returns
    run("R3", 1, 1, 2'd0, 16'h0010, 16'h0018, 16'h0028, 0, 0);
    run("R4", 0, 1, 2'd0, 16'h0010, 16'h0018, 16'h002F, 0, 0);
    setd(0, 4'h1, 1'b0, 2'd0, 1'b1, 1'b0);
    run("R5", 0, 1, 2'd0, 16'h0010, 16'h0018, 16'h002B, 1, 0);
    setd(0, 4'hB, 1'b1, 2'd0, 1'b1, 1'b0);
    run("R5", 0, 1, 2'd0, 16'h0010, 16'h0018, 16'h0030, 0, 0);
    setd(0, 4'hB, 1'b0, 2'd0, 1'b0, 1'b0);
    run("R5", 0, 1, 2'd0, 16'h0010, 16'h0018, 16'h0039, 2, 0);
    setd(0, 4'h3, 1'b0, 2'd0, 1'b1, 1'b0);
    run("R5", 0, 1, 2'd0, 16'h0010, 16'h0018, 16'h0040, 0, 1);
    setd(0, 4'hB, 1'b0, 2'd0, 1'b1, 1'b0);
    run("R5", 0, 1, 2'd0, 16'h0010, 16'h0018, 16'h0048, 3, 0);

    // code selector checks
    run("R6", 0, 0, 2'd0, 16'h0003, 16'h0018, 16'h0, 0, 0);
    setd(1, 4'hA, 1'b1, 2'd1, 1'b1, 1'b0);
    run("R7", 0, 0, 2'd2, 16'h0011, 16'h0019, 16'h0, 0, 0);
    run("R7", 0, 0, 2'd0, 16'h0008, 16'h0018, 16'h0, 1, 0);
    run("R2", 0, 0, 2'd1, 16'h0009, 16'h0018, 16'h0, 2, 1);

    // null stack selector cases
    setd(1, 4'hA, 1'b1, 2'd2, 1'b1, 1'b1);
    run("R8", 0, 0, 2'd0, 16'h0012, 16'h0002, 16'h0, 0, 0);
    run("R8", 1, 0, 2'd0, 16'h0012, 16'h0001, 16'h0, 0, 0);
    run("R8", 1, 0, 2'd0, 16'h0013, 16'h0000, 16'h0, 0, 0);
    setd(1, 4'hA, 1'b1, 2'd2, 1'b1, 1'b0);
    run("R8", 1, 0, 2'd0, 16'h0012, 16'h0000, 16'h0, 0, 0);

    // stack selector and descriptor
    run("R9", 0, 0, 2'd0, 16'h0013, 16'h0022, 16'h0, 0, 0);
    setd(2, 4'hA, 1'b1, 2'd3, 1'b1, 1'b0);
    run("R10", 0, 0, 2'd0, 16'h0013, 16'h0023, 16'h0, 1, 0);
    setd(2, 4'h0, 1'b1, 2'd3, 1'b1, 1'b0);
    run("R10", 0, 0, 2'd0, 16'h0013, 16'h0023, 16'h0, 0, 0);
    setd(2, 4'h2, 1'b0, 2'd3, 1'b1, 1'b0);
    run("R10", 0, 0, 2'd1, 16'h0013, 16'h0027, 16'h0, 0, 0);
    setd(2, 4'h2, 1'b1, 2'd2, 1'b0, 1'b0);
    run("R10", 0, 0, 2'd0, 16'h0013, 16'h0023, 16'h0, 2, 0);
    setd(2, 4'h6, 1'b1, 2'd3, 1'b0, 1'b0);
    run("R10", 0, 0, 2'd0, 16'h0013, 16'h002B, 16'h0, 1, 0);
    setd(2, 4'h3, 1'b1, 2'd3, 1'b1, 1'b0);
    run("R10", 1, 0, 2'd2, 16'h0013, 16'h0033, 16'h0, 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule